// File: doc/BRIEF.md
# Buck Converter PWM / Pulse-Skip Mode Controller

This block is the digital switch-control logic of a synchronous step-down converter. It runs on a fast clock. Once per switching period it receives a one-clock `cycle_tick`. Alongside the tick it receives single-bit comparator flags:

- a peak-current trip and an overcurrent trip;
- a light-current trip, set at roughly a fifth of the current limit;
- an inductor zero-cross flag;
- three output-window flags: above the upper band, at or below nominal, and below the lower band.

From these it drives the high-side and low-side switch gates and reports the operating mode.

Under load it runs fixed-frequency peak-current PWM. The high-side switch closes at each period start. It opens on the peak trip, or stays closed for the whole period when no trip comes (dropout). The low side then conducts until the next period. The block watches for zero crossings. After a run of consecutive periods that all show one, it moves to pulse skipping. In that mode:

- short high-side pulses still start on the tick and end at the light-current trip;
- the low side drains the inductor down to zero, and then both switches are left off;
- an over-band output stops pulsing, and pulsing restarts once the output is back at nominal;
- an under-band output returns the block to PWM.

An overcurrent flag opens the high side in any mode. A programmable dead time separates the two gates. Every flag is resynchronised through a two-flop chain before use.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset both gates are low, the counter of consecutive zero-cross periods is zero, and `mode` reads 0. The `mode` encoding is 0 = PWM, 1 = skip pulsing, 2 = skip idle. No gate rises before the first `cycle_tick`.
- R2: In PWM the high-side gate closes after each tick. It opens a few clocks after a peak trip. The low-side gate then stays high up to the next tick.
- R3: In PWM with no peak trip, the high-side gate stays high through the whole period and across the period boundary, giving 100% duty.
- R4: An overcurrent flag opens the high-side gate one clock after the flag leaves the synchroniser, in PWM and in skip pulsing alike.
- R5: Skip pulsing (`mode` = 1) is entered at the tick that closes the ZC_RUN-th consecutive PWM period with a zero crossing (default 16). Fifteen such periods leave the block in PWM.
- R6: A PWM period without any zero crossing clears the consecutive-period counter, so an earlier run does not add to a later one.
- R7: In skip pulsing the high side closes on the tick and opens at the light-current trip. The peak trip is not used in this mode. The low side then conducts until a zero crossing, after which both gates stay low.
- R8: An over-band flag during skip pulsing opens the high side at once and sets `mode` = 2. While the block is idle the high-side gate never rises.
- R9: From skip idle, a tick that finds the output at or below nominal starts a new pulse and sets `mode` back to 1.
- R10: A tick that finds the output below the lower band in either skip mode returns the block to PWM (`mode` = 0). The consecutive-period count restarts from zero.
- R11: The two gates are never high together. After one gate falls, the other gate rises only after at least DT_CYCLES clocks with both gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | One-clock pulse that starts each switching period |
| pk_trip | input | 1 | Peak-current comparator flag (asynchronous) |
| oc_trip | input | 1 | Overcurrent comparator flag (asynchronous) |
| lite_trip | input | 1 | Light-current (about 20% of limit) comparator flag |
| zc_flag | input | 1 | Inductor zero-cross flag |
| vout_high | input | 1 | Output above nominal plus 1.5% |
| vout_nom | input | 1 | Output at or below nominal |
| vout_low | input | 1 | Output below nominal minus 1.5% |
| hs_gate | output | 1 | High-side switch gate |
| ls_gate | output | 1 | Low-side switch gate |
| mode | output | 2 | Operating mode: 0 PWM, 1 skip pulsing, 2 skip idle |

## Verification
The bench targets the exact length of the zero-cross run. It feeds fifteen qualifying periods and checks that the block stays in PWM, then breaks a long run with one empty period. An off-by-one counter would enter skip a period early or late, and a counter that is never cleared would enter skip in the middle of the broken run.

It checks that the light-current trip, and not the peak trip, ends a skip pulse. A controller that confused the two would overshoot in skip. It also checks that an over-band output stops pulsing, that the high side stays low in idle, and that the block resumes only at nominal and returns to PWM only below the band.

Random zero-cross patterns, compared against a bench run-length model, catch counting slips. A gate monitor over the whole run catches shoot-through or a short dead time.

// File: rtl/buck_ctl_pkg.sv
package buck_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_PWM   = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_IDLE  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  typedef struct packed {
    logic pk;
    logic oc;
    logic i20;
    logic zc;
    logic hi;
    logic nom;
    logic lo;
  } flags_t;

  localparam int NFLAGS = $bits(flags_t);

  // High-side conduction hands over to the low side; other phases are kept.
  function automatic phase_e tail_phase(phase_e ph);
    return (ph == PH_HIGH) ? PH_LOW : ph;
  endfunction

  // Low-side conduction ends at a zero crossing.
  function automatic phase_e drain_phase(phase_e ph, logic zc);
    return (ph == PH_LOW && zc) ? PH_OFF : ph;
  endfunction

  // One step of a skip pulse: end the high side on the trip, drain to zero.
  function automatic phase_e pulse_step(phase_e ph, logic trip, logic zc);
    if (ph == PH_HIGH && trip) return PH_LOW;
    return drain_phase(ph, zc);
  endfunction

endpackage

// File: rtl/buck_flag_sync.sv
module buck_flag_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/buck_zc_counter.sv
module buck_zc_counter #(
  parameter int RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic zc_s,
  input  logic count_en,
  output logic run_full
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] count_q;
  logic          zc_seen_q;
  logic          zc_cycle;

  function automatic logic [CW-1:0] next_count(logic [CW-1:0] c, logic z);
    return z ? c + 1'b1 : '0;
  endfunction

  assign zc_cycle = zc_seen_q | zc_s;
  assign run_full = count_en & tick & zc_cycle & (count_q == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_seen_q <= 1'b0;
    end else if (tick) begin
      zc_seen_q <= 1'b0;
    end else if (zc_s) begin
      zc_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!count_en) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= run_full ? '0 : next_count(count_q, zc_cycle);
    end
  end

  // R6
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && tick && !zc_seen_q && !zc_s) |=> (count_q == '0));

  // R1
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q < CW'(RUN)));
endmodule

// File: rtl/buck_mode_fsm.sv
module buck_mode_fsm
  import buck_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  flags_t fl,
  input  logic   run_full,
  output mode_e  mode_q,
  output logic   hs_req,
  output logic   ls_req,
  output logic   count_en
);
  mode_e  mode_n;
  phase_e ph_q, ph_n;

  always_comb begin
    mode_n = mode_q;
    ph_n   = ph_q;
    case (mode_q)
      MODE_PWM: begin
        if (tick) begin
          ph_n = PH_HIGH;
          if (run_full) mode_n = MODE_PULSE;
        end else if (ph_q == PH_HIGH && (fl.pk || fl.oc)) begin
          ph_n = PH_LOW;
        end
      end
      MODE_PULSE: begin
        if (tick && fl.lo) begin
          mode_n = MODE_PWM;
          ph_n   = PH_HIGH;
        end else if (fl.hi) begin
          mode_n = MODE_IDLE;
          ph_n   = tail_phase(ph_q);
        end else if (tick) begin
          ph_n = PH_HIGH;
        end else begin
          ph_n = pulse_step(ph_q, fl.i20 || fl.oc, fl.zc);
        end
      end
      default: begin
        if (tick && fl.lo) begin
          mode_n = MODE_PWM;
          ph_n   = PH_HIGH;
        end else if (tick && fl.nom && !fl.hi) begin
          mode_n = MODE_PULSE;
          ph_n   = PH_HIGH;
        end else begin
          ph_n = drain_phase(tail_phase(ph_q), fl.zc);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PWM;
      ph_q   <= PH_OFF;
    end else begin
      mode_q <= mode_n;
      ph_q   <= ph_n;
    end
  end

  assign hs_req   = (ph_q == PH_HIGH) && !fl.oc;
  assign ls_req   = (ph_q == PH_LOW);
  assign count_en = (mode_q == MODE_PWM);

  // R5
  skip_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULSE && $past(mode_q) == MODE_PWM) |-> $past(run_full));

  // R8
  over_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULSE && fl.hi && !(tick && fl.lo)) |=> (mode_q == MODE_IDLE));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |-> !hs_req);

  // R10
  low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_PWM && tick && fl.lo) |=> (mode_q == MODE_PWM));
endmodule

// File: rtl/buck_gate_cell.sv
module buck_gate_cell #(
  parameter int DT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic other_gate,
  input  logic other_ready,
  output logic gate,
  output logic ready
);
  localparam int DW = $clog2(DT + 1);

  logic [DW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate    <= 1'b0;
      low_cnt <= DW'(DT);
    end else begin
      gate <= req && (gate || (!other_gate && other_ready));
      if (gate) low_cnt <= '0;
      else if (low_cnt != DW'(DT)) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign ready = (low_cnt == DW'(DT));
endmodule

// File: rtl/buck_dead_time.sv
module buck_dead_time #(
  parameter int DT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_gate,
  output logic ls_gate
);
  logic [1:0] req;
  logic [1:0] gate;
  logic [1:0] ready;

  assign req = {ls_req, hs_req};

  genvar i;
  generate
    for (i = 0; i < 2; i++) begin : g_side
      buck_gate_cell #(.DT(DT)) u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req[i]),
        .other_gate  (gate[1-i]),
        .other_ready (ready[1-i]),
        .gate        (gate[i]),
        .ready       (ready[i])
      );
    end
  endgenerate

  assign hs_gate = gate[0];
  assign ls_gate = gate[1];

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R11
  ls_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(!hs_gate));

  // R11
  hs_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(!ls_gate));
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ZC_RUN      = 16,
  parameter int DT_CYCLES   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_tick,
  input  logic       pk_trip,
  input  logic       oc_trip,
  input  logic       lite_trip,
  input  logic       zc_flag,
  input  logic       vout_high,
  input  logic       vout_nom,
  input  logic       vout_low,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic [1:0] mode
);
  logic [NFLAGS-1:0] raw_flags;
  logic [NFLAGS-1:0] sync_flags;
  flags_t            fs;
  logic              oc_s;
  logic              run_full;
  logic              count_en;
  logic              hs_req;
  logic              ls_req;
  mode_e             mode_q;

  assign raw_flags = {pk_trip, oc_trip, lite_trip, zc_flag, vout_high, vout_nom, vout_low};

  buck_flag_sync #(.W(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (sync_flags)
  );

  assign fs   = flags_t'(sync_flags);
  assign oc_s = fs.oc;

  buck_zc_counter #(.RUN(ZC_RUN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cycle_tick),
    .zc_s     (fs.zc),
    .count_en (count_en),
    .run_full (run_full)
  );

  buck_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cycle_tick),
    .fl       (fs),
    .run_full (run_full),
    .mode_q   (mode_q),
    .hs_req   (hs_req),
    .ls_req   (ls_req),
    .count_en (count_en)
  );

  buck_dead_time #(.DT(DT_CYCLES)) u_dt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_req  (hs_req),
    .ls_req  (ls_req),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate)
  );

  assign mode = mode_q;

  // R4
  oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_s |=> !hs_gate);

  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && $past(mode_q) == MODE_IDLE) |-> !hs_gate);
endmodule

// File: tb/sim_buck_mode_ctrl.sv
module sim_buck_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 32;
  localparam int DT         = 3;
  localparam int RUN        = 16;
  localparam logic [1:0] M_PWM   = 2'd0;
  localparam logic [1:0] M_PULSE = 2'd1;
  localparam logic [1:0] M_IDLE  = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_tick = 1'b0;
  logic pk_trip = 1'b0, oc_trip = 1'b0, lite_trip = 1'b0, zc_flag = 1'b0;
  logic vout_high = 1'b0, vout_nom = 1'b0, vout_low = 1'b0;
  logic hs_gate, ls_gate;
  logic [1:0] mode;

  buck_mode_ctrl #(.SYNC_STAGES(2), .ZC_RUN(RUN), .DT_CYCLES(DT)) u0 (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .pk_trip(pk_trip), .oc_trip(oc_trip), .lite_trip(lite_trip), .zc_flag(zc_flag),
    .vout_high(vout_high), .vout_nom(vout_nom), .vout_low(vout_low),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .mode(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic       hs_rec [CYC];
  logic       ls_rec [CYC];
  logic [1:0] md_rec [CYC];

  // gate monitor: overlap and dead gap
  int overlap_err = 0;
  int gap_err = 0;
  int low_run = 100;
  int last_on = -1;
  logic hs_prev = 1'b0, ls_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_gate && ls_gate) overlap_err++;
      if (hs_gate && !hs_prev && last_on == 1 && low_run < DT) gap_err++;
      if (ls_gate && !ls_prev && last_on == 0 && low_run < DT) gap_err++;
      if (hs_gate) last_on = 0;
      if (ls_gate) last_on = 1;
      if (!hs_gate && !ls_gate) low_run++;
      else low_run = 0;
      hs_prev = hs_gate;
      ls_prev = ls_gate;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_pulse(int k, int at, int w);
    return (at >= 0) && (k >= at) && (k < at + w);
  endfunction

  // run-length model of the consecutive zero-cross counter
  function automatic int run_next(int c, bit z);
    return z ? c + 1 : 0;
  endfunction

  task automatic do_cycle(int pk_at, int i20_at, int oc_at, int zc_at, int hi_at);
    for (int k = 0; k < CYC; k++) begin
      @(negedge clk);
      hs_rec[k] = hs_gate;
      ls_rec[k] = ls_gate;
      md_rec[k] = mode;
      cycle_tick = (k == 0);
      pk_trip    = in_pulse(k, pk_at, 4);
      lite_trip  = in_pulse(k, i20_at, 4);
      oc_trip    = in_pulse(k, oc_at, 2);
      zc_flag    = in_pulse(k, zc_at, 4);
      if (k == hi_at) vout_high = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int c;
    bit prev_zc;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", hs_gate, 0, "hs_gate after reset");
    check("R1", ls_gate, 0, "ls_gate after reset");
    check("R1", mode, M_PWM, "mode after reset");

    // R3 dropout: no peak trip, high side held through two periods
    do_cycle(-1, -1, -1, -1, -1);
    ok = 1;
    for (int k = 2; k < CYC; k++) if (hs_rec[k] !== 1'b1) ok = 0;
    do_cycle(-1, -1, -1, -1, -1);
    for (int k = 0; k < CYC; k++) if (hs_rec[k] !== 1'b1 || ls_rec[k] !== 1'b0) ok = 0;
    check("R3", ok, 1, "hs held high across periods");

    // R2 peak-current PWM
    do_cycle(10, -1, -1, -1, -1);
    check("R2", hs_rec[8], 1, "hs before peak trip");
    check("R2", {hs_rec[28], ls_rec[28]}, 2'b01, "gates after peak trip");
    do_cycle(10, -1, -1, -1, -1);
    check("R2", {hs_rec[8], ls_rec[8]}, 2'b10, "hs back after next tick");

    // R4 overcurrent in PWM without peak trip
    do_cycle(-1, -1, 10, -1, -1);
    check("R4", hs_rec[14], 0, "hs after overcurrent (PWM)");
    check("R4", ls_rec[28], 1, "ls after overcurrent (PWM)");

    // R6 broken run then R5 exact length
    for (int n = 0; n < 15; n++) do_cycle(10, -1, -1, 20, -1);
    do_cycle(10, -1, -1, -1, -1);
    for (int n = 0; n < 15; n++) do_cycle(10, -1, -1, 20, -1);
    check("R6", md_rec[4], M_PWM, "mode after broken run");
    do_cycle(10, -1, -1, 20, -1);
    check("R5", md_rec[4], M_PWM, "mode after 15 zero-cross periods");

    // R7 skip pulse ended by light-current trip, drained to zero
    do_cycle(-1, 10, -1, 22, -1);
    check("R5", md_rec[4], M_PULSE, "mode after 16 zero-cross periods");
    check("R7", hs_rec[8], 1, "hs at start of skip pulse");
    check("R7", {hs_rec[20], ls_rec[20]}, 2'b01, "gates after light trip");
    check("R7", {hs_rec[30], ls_rec[30]}, 2'b00, "gates after zero cross");

    // R8 over-band stops pulsing
    do_cycle(-1, -1, -1, 20, 6);
    check("R8", md_rec[16], M_IDLE, "mode after over-band");
    check("R8", {hs_rec[16], ls_rec[16]}, 2'b01, "gates after over-band");
    check("R8", {hs_rec[30], ls_rec[30]}, 2'b00, "gates drained in idle");
    vout_high = 1'b0;
    do_cycle(-1, -1, -1, -1, -1);
    ok = 1;
    for (int k = 1; k < CYC; k++) if (hs_rec[k] !== 1'b0) ok = 0;
    check("R8", ok, 1, "hs stays low in idle");
    check("R8", md_rec[16], M_IDLE, "mode stays idle");

    // R9 resume at nominal
    vout_nom = 1'b1;
    do_cycle(-1, -1, -1, -1, -1);
    do_cycle(-1, -1, -1, -1, -1);
    check("R9", md_rec[4], M_PULSE, "mode after nominal");
    check("R9", hs_rec[4], 1, "hs pulse after nominal");
    vout_nom = 1'b0;

    // R4 overcurrent in skip pulsing, then R10 low band
    vout_low = 1'b1;
    do_cycle(-1, -1, 10, -1, -1);
    check("R4", hs_rec[14], 0, "hs after overcurrent (skip)");
    do_cycle(10, -1, -1, -1, -1);
    check("R10", md_rec[4], M_PWM, "mode after low band");
    vout_low = 1'b0;
    for (int n = 0; n < 15; n++) do_cycle(10, -1, -1, 20, -1);
    do_cycle(10, -1, -1, -1, -1);
    check("R10", md_rec[4], M_PWM, "counter restarted after return");

    // random zero-cross patterns against the run-length model (R5, R6)
    c = 0;
    prev_zc = 0;
    for (int n = 0; n < 160; n++) begin
      bit zc_now;
      int pk_at;
      bit exp_skip;
      c = run_next(c, prev_zc);
      exp_skip = (c == RUN);
      if (exp_skip) c = 0;
      zc_now = ($urandom_range(0, 15) != 0);
      pk_at = $urandom_range(6, 14);
      do_cycle(pk_at, -1, -1, zc_now ? 20 : -1, -1);
      check(exp_skip ? "R5" : "R6", md_rec[4], exp_skip ? M_PULSE : M_PWM, "random run mode");
      prev_zc = zc_now;
      if (exp_skip) begin
        vout_low = 1'b1;
        do_cycle(-1, -1, -1, -1, -1);
        do_cycle(pk_at, -1, -1, -1, -1);
        check("R10", md_rec[4], M_PWM, "random return to PWM");
        vout_low = 1'b0;
        c = 0;
        prev_zc = 0;
      end
    end

    // R11 gate monitor over the whole run
    check("R11", overlap_err, 0, "clocks with both gates high");
    check("R11", gap_err, 0, "dead gaps shorter than DT");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule